// File: doc/BRIEF.md
# DRAM Bank Timing Guard

This block sits beside the command issue stage of a DDR2-style memory controller. It keeps the open/closed state of every bank and judges each command against the minimum spacing rules that apply to one bank. Those rules are the activate-to-column delay, the minimum row active time, the row precharge recovery and the row cycle time. Each command presented on the strobe gets a verdict one clock later. An accepted command updates the bank state. A rejected command leaves all state alone and raises a sticky violation flag.

The timing limits are given as picosecond parameters together with the controller clock period. At elaboration they are turned into cycle counts by rounding up. A per-bank ready vector tells the scheduler which banks would accept an activate on the next clock. Auto-precharge on a column command is tracked without a separate pending state: the bank is closed at once, and its precharge recovery is counted from the later of the column command and the expiry of its row active time.

Top module: `dram_bank_guard`

## Requirements
- R1: After reset every bank is closed, every counter is expired, `bank_rdy_o` is all ones, `resp_vld_o` is 0 and `viol_o` is 0.
- R2: Operation code 0 (activate) is accepted only for a closed bank whose precharge recovery and row cycle windows have expired. An activate to an open bank is rejected.
- R3: Codes 1 (read) and 2 (write) are accepted only for an open bank, and only once at least tRCD cycles have passed since that bank's activate.
- R4: Code 3 (precharge one bank) on an open bank is accepted only once at least tRAS cycles have passed since its activate, and it closes the bank. On a closed bank it is accepted and changes nothing.
- R5: After a single-bank precharge at cycle t, an activate to that bank is legal no earlier than t+tRP. After an activate at cycle t, the next activate to that bank is legal no earlier than t+tRC.
- R6: Code 4 (precharge all) is accepted only if every open bank has passed tRAS. It closes all open banks, and their activate becomes legal no earlier than t+tRP+1.
- R7: A read or write with `cmd_ap_i` = 1 closes its bank. The next activate to that bank is legal no earlier than max(t, activate time + tRAS) + tRP.
- R8: Code 5 (refresh) is accepted only when every bank is closed and every bank's precharge recovery has expired. It changes no bank state.
- R9: A rejected command, including the reserved codes 6 and 7, changes no bank state and sets `viol_o`. `viol_o` stays at 1 until reset.
- R10: `resp_vld_o` and `resp_ok_o` report the command sampled on the previous rising edge. `bank_rdy_o[b]` is 1 exactly when an activate to bank b on the next edge would be accepted.
- R11: Each cycle count is the picosecond value divided by the clock period, rounded up, with a minimum of 1. For example, 13125 ps at 2500 ps gives 6 cycles.
- R12: Banks are independent: a command to one bank never alters the state or counters of another, except precharge all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Operation code (0 activate, 1 read, 2 write, 3 precharge one, 4 precharge all, 5 refresh) |
| cmd_bank_i | input | BAW (3) | Target bank |
| cmd_ap_i | input | 1 | Auto-precharge request with read or write |
| resp_vld_o | output | 1 | Verdict valid, one cycle after the command |
| resp_ok_o | output | 1 | 1 = command legal and applied |
| viol_o | output | 1 | Sticky violation flag |
| bank_rdy_o | output | NB (8) | Per bank: an activate on the next edge would be accepted |

## Verification
A command driven before rising edge t has its verdict on `resp_vld_o`/`resp_ok_o` right after edge t. The same edge updates `viol_o` and the state behind `bank_rdy_o`, so all three are due one register stage after the stimulus. The bench drives each command on a falling edge and counts rising edges itself. After edge t it compares the verdict, the sticky flag and the ready vector on the next falling edge. The reference model predicts the ready bits for an activate at edge t+1. Every window is held as the absolute cycle at which it opens, so an off-by-one in any counter reload shows up in the verdict or in the ready vector.

// File: rtl/dg_pkg.sv
package dg_pkg;

    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_PRE  = 3'd3,
        OP_PREA = 3'd4,
        OP_REF  = 3'd5
    } op_e;

    typedef struct packed {
        logic vld;
        logic ok;
        logic viol;
    } resp_t;

    // Ceiling division of a picosecond limit by the clock period, at least 1.
    function automatic int ps_to_cyc(input int ps, input int clk_ps);
        int c;
        c = (ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/dg_bank.sv
module dg_bank #(
    parameter int CW    = 8,
    parameter int C_RCD = 1,
    parameter int C_RAS = 1,
    parameter int C_RP  = 1,
    parameter int C_RC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic col_i,
    input  logic ap_i,
    input  logic pre_i,
    input  logic prea_i,
    output logic open_o,
    output logic act_ok_o,
    output logic col_ok_o,
    output logic pre_ok_o,
    output logic rp_done_o
);

    localparam logic [CW-1:0] LD_RCD = CW'(C_RCD - 1);
    localparam logic [CW-1:0] LD_RAS = CW'(C_RAS - 1);
    localparam logic [CW-1:0] LD_RP  = CW'(C_RP - 1);
    localparam logic [CW-1:0] LD_RPA = CW'(C_RP);
    localparam logic [CW-1:0] LD_RC  = CW'(C_RC - 1);

    typedef struct packed {
        logic          open;
        logic [CW-1:0] rcd;
        logic [CW-1:0] ras;
        logic [CW-1:0] rp;
        logic [CW-1:0] rc;
    } bst_t;

    bst_t st_d, st_q;

    function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.rcd = dec(st_q.rcd);
        st_d.ras = dec(st_q.ras);
        st_d.rp  = dec(st_q.rp);
        st_d.rc  = dec(st_q.rc);
        if (act_i) begin
            st_d.open = 1'b1;
            st_d.rcd  = LD_RCD;
            st_d.ras  = LD_RAS;
            st_d.rc   = LD_RC;
        end else if (col_i && ap_i) begin
            // internal precharge waits for tRAS, then tRP runs
            st_d.open = 1'b0;
            st_d.rp   = st_q.ras + LD_RP;
        end else if (pre_i && st_q.open) begin
            st_d.open = 1'b0;
            st_d.rp   = LD_RP;
        end else if (prea_i && st_q.open) begin
            st_d.open = 1'b0;
            st_d.rp   = LD_RPA;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o    = st_q.open;
    assign rp_done_o = (st_q.rp == '0);
    assign act_ok_o  = !st_q.open && (st_q.rp == '0) && (st_q.rc == '0);
    assign col_ok_o  = st_q.open && (st_q.rcd == '0);
    assign pre_ok_o  = !st_q.open || (st_q.ras == '0);

    a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> st_q.open);
    a_r5_act_windows: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> (st_q.rp == '0 && st_q.rc == '0));
    a_r3_col_window: assert property (@(posedge clk) disable iff (!rst_n)
        col_i |-> (st_q.open && st_q.rcd == '0));
    a_r4_pre_window: assert property (@(posedge clk) disable iff (!rst_n)
        ((pre_i || prea_i) && st_q.open) |-> st_q.ras == '0);
    a_r9_open_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && !col_i && !pre_i && !prea_i) |=> st_q.open);
    a_r12_closed_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.open && !act_i) |=> !st_q.open);

endmodule

// File: rtl/dram_bank_guard.sv
module dram_bank_guard #(
    parameter int NB       = 8,
    parameter int CLK_PS   = 2500,
    parameter int T_RCD_PS = 15000,
    parameter int T_RAS_PS = 45000,
    parameter int T_RP_PS  = 15000,
    parameter int T_RC_PS  = 60000,
    localparam int BAW     = $clog2(NB)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_vld_i,
    input  logic [2:0]     cmd_op_i,
    input  logic [BAW-1:0] cmd_bank_i,
    input  logic           cmd_ap_i,
    output logic           resp_vld_o,
    output logic           resp_ok_o,
    output logic           viol_o,
    output logic [NB-1:0]  bank_rdy_o
);
    import dg_pkg::*;

    localparam int C_RCD = ps_to_cyc(T_RCD_PS, CLK_PS);
    localparam int C_RAS = ps_to_cyc(T_RAS_PS, CLK_PS);
    localparam int C_RP  = ps_to_cyc(T_RP_PS, CLK_PS);
    localparam int C_RC  = ps_to_cyc(T_RC_PS, CLK_PS);
    localparam int CW    = $clog2(C_RAS + C_RP + C_RC + 1);

    logic [NB-1:0] open_v, act_ok_v, col_ok_v, pre_ok_v, rp_done_v;
    op_e           op;
    logic          legal, acc;
    resp_t         rs_d, rs_q;

    always_comb begin
        op = op_e'(cmd_op_i);
        unique case (op)
            OP_ACT:       legal = act_ok_v[cmd_bank_i];
            OP_RD, OP_WR: legal = col_ok_v[cmd_bank_i];
            OP_PRE:       legal = pre_ok_v[cmd_bank_i];
            OP_PREA:      legal = &pre_ok_v;
            OP_REF:       legal = !(|open_v) && (&rp_done_v);
            default:      legal = 1'b0;
        endcase
        acc = cmd_vld_i && legal;

        rs_d.vld  = cmd_vld_i;
        rs_d.ok   = acc;
        rs_d.viol = rs_q.viol || (cmd_vld_i && !legal);
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        assign hit = (cmd_bank_i == BAW'(b));
        dg_bank #(
            .CW(CW), .C_RCD(C_RCD), .C_RAS(C_RAS), .C_RP(C_RP), .C_RC(C_RC)
        ) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (acc && hit && op == OP_ACT),
            .col_i    (acc && hit && (op == OP_RD || op == OP_WR)),
            .ap_i     (cmd_ap_i),
            .pre_i    (acc && hit && op == OP_PRE),
            .prea_i   (acc && op == OP_PREA),
            .open_o   (open_v[b]),
            .act_ok_o (act_ok_v[b]),
            .col_ok_o (col_ok_v[b]),
            .pre_ok_o (pre_ok_v[b]),
            .rp_done_o(rp_done_v[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign resp_vld_o = rs_q.vld;
    assign resp_ok_o  = rs_q.ok;
    assign viol_o     = rs_q.viol;
    assign bank_rdy_o = act_ok_v;

    a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_i |=> resp_vld_o);
    a_r10_no_stray_ok: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_vld_i |=> !resp_vld_o && !resp_ok_o);
    a_r9_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld_o && !resp_ok_o) |-> viol_o);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> viol_o);
    a_r8_ref_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_i && cmd_op_i == 3'd5 && (|open_v)) |=> !resp_ok_o);
    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_i && cmd_op_i[2:1] == 2'b11) |=> !resp_ok_o);

endmodule

// File: tb/test_dram_bank_guard.sv
`timescale 1ns/1ps
module test_dram_bank_guard;

    // R11: 12500/2500=5, 45000/2500=18, 13125/2500 rounds up to 6, 70000/2500=28
    localparam int N_RCD = 5;
    localparam int N_RAS = 18;
    localparam int N_RP  = 6;
    localparam int N_RC  = 28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_vld_i = 1'b0;
    logic [2:0] cmd_op_i = '0;
    logic [2:0] cmd_bank_i = '0;
    logic       cmd_ap_i = 1'b0;
    logic       resp_vld_o, resp_ok_o, viol_o;
    logic [7:0] bank_rdy_o;

    dram_bank_guard #(
        .NB(8), .CLK_PS(2500), .T_RCD_PS(12500), .T_RAS_PS(45000),
        .T_RP_PS(13125), .T_RC_PS(70000)
    ) i_dram_bank_guard (
        .clk(clk), .rst_n(rst_n), .cmd_vld_i(cmd_vld_i), .cmd_op_i(cmd_op_i),
        .cmd_bank_i(cmd_bank_i), .cmd_ap_i(cmd_ap_i), .resp_vld_o(resp_vld_o),
        .resp_ok_o(resp_ok_o), .viol_o(viol_o), .bank_rdy_o(bank_rdy_o)
    );

    always #4 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  finished = 0;
    bit  open_m [8];
    int  col_at [8];
    int  pre_at [8];
    int  rp_at  [8];
    int  rc_at  [8];
    bit  sticky_m = 0;

    task automatic chk(input bit cond, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
                     tag, what, cyc, act, exp);
        end
    endtask

    // Reference model: each window kept as the first legal cycle.
    function automatic bit model_cmd(input int op, input int b, input bit ap, input int t);
        bit ok;
        ok = 0;
        case (op)
            0: if (!open_m[b] && t >= rp_at[b] && t >= rc_at[b]) begin
                   ok = 1; open_m[b] = 1;
                   col_at[b] = t + N_RCD; pre_at[b] = t + N_RAS; rc_at[b] = t + N_RC;
               end
            1, 2: if (open_m[b] && t >= col_at[b]) begin
                   ok = 1;
                   if (ap) begin
                       open_m[b] = 0;
                       rp_at[b] = ((t > pre_at[b]) ? t : pre_at[b]) + N_RP;
                   end
               end
            3: if (!open_m[b] || t >= pre_at[b]) begin
                   ok = 1;
                   if (open_m[b]) begin open_m[b] = 0; rp_at[b] = t + N_RP; end
               end
            4: begin
                   ok = 1;
                   for (int i = 0; i < 8; i++)
                       if (open_m[i] && t < pre_at[i]) ok = 0;
                   if (ok)
                       for (int i = 0; i < 8; i++)
                           if (open_m[i]) begin open_m[i] = 0; rp_at[i] = t + N_RP + 1; end
               end
            5: begin
                   ok = 1;
                   for (int i = 0; i < 8; i++)
                       if (open_m[i] || t < rp_at[i]) ok = 0;
               end
            default: ok = 0;
        endcase
        return ok;
    endfunction

    function automatic logic [7:0] exp_rdy();
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = !open_m[i] && (cyc + 1 >= rp_at[i]) && (cyc + 1 >= rc_at[i]);
        return r;
    endfunction

    task automatic step(input bit vld, input int op, input int b, input bit ap,
                        input string tag);
        bit ok_e;
        ok_e = 0;
        if (vld) begin
            ok_e = model_cmd(op, b, ap, cyc + 1);
            if (!ok_e) sticky_m = 1;
        end
        cmd_vld_i  = vld;
        cmd_op_i   = 3'(op);
        cmd_bank_i = 3'(b);
        cmd_ap_i   = ap;
        @(posedge clk);
        cyc++;
        @(negedge clk);
        cmd_vld_i = 0;
        cmd_ap_i  = 0;
        chk(resp_vld_o == vld, "R10", "resp_vld", int'(resp_vld_o), int'(vld));
        if (vld) chk(resp_ok_o == ok_e, tag, "verdict", int'(resp_ok_o), int'(ok_e));
        chk(viol_o == sticky_m, "R9", "viol", int'(viol_o), int'(sticky_m));
        chk(bank_rdy_o == exp_rdy(), "R10", "bank_rdy", int'(bank_rdy_o), int'(exp_rdy()));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            open_m[i] = 0; col_at[i] = 0; pre_at[i] = 0; rp_at[i] = 0; rc_at[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        // R1: reset state
        chk(bank_rdy_o == 8'hFF, "R1", "bank_rdy", int'(bank_rdy_o), 8'hFF);
        chk(viol_o == 1'b0, "R1", "viol", int'(viol_o), 0);
        chk(resp_vld_o == 1'b0, "R1", "resp_vld", int'(resp_vld_o), 0);

        step(1, 0, 0, 0, "R2");          // activate closed bank: accepted
        step(1, 0, 0, 0, "R2");          // activate open bank: rejected
        step(1, 1, 0, 0, "R3");          // read before tRCD
        step(1, 2, 2, 0, "R3");          // write to closed bank
        idle(1);
        step(1, 1, 0, 0, "R3");          // read exactly at tRCD
        step(1, 0, 1, 0, "R12");         // other bank independent
        step(1, 3, 0, 0, "R4");          // precharge before tRAS
        idle(10);
        step(1, 3, 0, 0, "R4");          // precharge exactly at tRAS
        step(1, 3, 0, 0, "R4");          // precharge on idle bank
        step(1, 0, 0, 0, "R5");          // inside tRP
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, "R5"); // tRP then tRC bound
        idle(4);
        step(1, 2, 0, 1, "R7");          // write with auto-precharge, tRAS pending
        for (int i = 0; i < 24; i++) step(1, 0, 0, 0, "R7");
        step(1, 4, 0, 0, "R6");          // precharge all while bank 0 inside tRAS
        step(1, 5, 0, 0, "R8");          // refresh with open banks
        for (int i = 0; i < 20; i++) step(1, 4, 0, 0, "R6");
        for (int i = 0; i < 9; i++)  step(1, 0, 1, 0, "R6");
        step(1, 3, 1, 0, "R12");
        step(1, 6, 3, 0, "R9");          // reserved code
        step(1, 7, 3, 0, "R9");
        for (int i = 0; i < 30; i++) step(1, 5, 0, 0, "R8");
        step(1, 0, 4, 0, "R2");
        idle(N_RAS + 2);
        step(1, 1, 4, 1, "R7");          // read with auto-precharge after tRAS
        for (int i = 0; i < 8; i++) step(1, 0, 4, 0, "R7");

        // mixed traffic over few banks to force collisions
        for (int i = 0; i < 3000; i++) begin
            int r;
            int op;
            r = int'($urandom_range(0, 99));
            if (r < 25)      op = 0;
            else if (r < 45) op = 1;
            else if (r < 60) op = 2;
            else if (r < 78) op = 3;
            else if (r < 84) op = 4;
            else if (r < 88) op = 5;
            else             op = 6 + (r & 1);
            step(($urandom_range(0, 9) < 7), op, int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 1)), "R12");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule